// File: doc/BRIEF.md
# Sleep Wake-Up and Reset-Cause Controller

This block sits beside a small controller core and owns its low-power state. A sleep request puts the device into power-down: the oscillator enable drops, the watchdog receives a clear pulse, and four status flags are loaded so that software can later see that a sleep took place. While asleep, the block watches for five wake sources:

- an enabled external reset pin,
- a watchdog timeout,
- a change on three monitored pins (with wake-on-change on),
- a comparator output change (with comparator wake on),
- a brown-out.

Every wake source ends sleep with a fixed-length device reset request rather than a resume of execution.

The flags survive that reset. The timeout flag, the power-down flag, the pin-wake flag and the comparator-wake flag together identify which event woke the device. Outside sleep, a watchdog timeout, an enabled external reset or a brown-out also request a device reset. Only a power-on, applied on the asynchronous power-on input, reloads every flag.

Top module: `wrc_top`

## Requirements
- R1: While power-on is high and afterwards until another event, the flags read timeout=1, power-down=1, pin-wake=0, comparator-wake=0, with sleeping=0, oscillator enable=1 and reset request=0.
- R2: An accepted sleep request makes sleeping=1 and oscillator enable=0 from the next cycle. In that cycle the timeout flag is set, the power-down flag is cleared, both wake flags are cleared, and the watchdog clear output is high for exactly one cycle.
- R3: A watchdog timeout pulse, awake or asleep, clears the timeout flag and starts a reset request. If asleep, it ends sleep.
- R4: The external reset pin starts a reset request only when its enable is high; with the enable low it is ignored, even asleep. It leaves timeout and power-down flags unchanged.
- R5: Monitored pins pass a two-stage synchronizer. While asleep with wake-on-change high, a synchronized value differing from the reference sets pin-wake=1 and starts a reset request.
- R6: While asleep with comparator wake high, a synchronized comparator value differing from its value at sleep entry sets comparator-wake=1 and starts a reset request.
- R7: Pin or comparator changes while awake, or with the matching wake enable low, set no flag and request no reset.
- R8: The pin reference is recaptured on every port-access strobe and on sleep entry. After a port access, the pins as they then stand do not wake the device.
- R9: A brown-out pulse starts a reset request and leaves all four flags unchanged.
- R10: A reset request is high for exactly 4 consecutive cycles, and sleeping drops (oscillator enable rises) at the same edge the request rises.
- R11: While a reset request is active, new sleep requests and new reset triggers are ignored.
- R12: A sleep request and a watchdog timeout in the same cycle produce a reset with the timeout flag cleared; sleep is not entered and no watchdog clear is issued.
- R13: All four flags keep their values through the reset request that ends sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| bod_i | input | 1 | Brown-out indication pulse |
| sleep_req_i | input | 1 | Sleep request strobe |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| ext_rst_i | input | 1 | External reset pin, active high |
| ext_rst_en_i | input | 1 | Pin configured as reset |
| mon_pins_i | input | NPINS | Monitored general-purpose pins |
| pin_wake_en_i | input | 1 | Wake-on-change enable |
| cmp_i | input | 1 | Comparator output |
| cmp_wake_en_i | input | 1 | Comparator wake enable |
| port_acc_i | input | 1 | Port-access strobe |
| to_flag_o | output | 1 | Timeout flag (0 = watchdog timed out) |
| pd_flag_o | output | 1 | Power-down flag (0 = sleep was entered) |
| pin_wake_o | output | 1 | Pin-change wake flag |
| cmp_wake_o | output | 1 | Comparator wake flag |
| osc_en_o | output | 1 | Oscillator driver enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| sleeping_o | output | 1 | Device is in power-down |
| dev_rst_o | output | 1 | Device reset request |

## Verification
The two functions that can meet in one cycle are sleep entry and a reset trigger. The watchdog timeout is the trigger that matters most, because both of these functions write the timeout flag. The bench drives a sleep request and a timeout pulse on the same edge, and a second sleep request while the resulting reset pulse is still running. A behavioural model scores both cases on every clock. It expects the reset to win, the timeout flag to read 0, no watchdog clear pulse, and the late sleep request to be dropped.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  typedef struct packed {
    logic to;
    logic pd;
    logic pin;
    logic cmp;
  } wrc_flags_t;

  localparam wrc_flags_t FLAGS_POR = '{to: 1'b1, pd: 1'b1, pin: 1'b0, cmp: 1'b0};

  // flags loaded on sleep entry
  function automatic wrc_flags_t flags_on_sleep();
    return '{to: 1'b1, pd: 1'b0, pin: 1'b0, cmp: 1'b0};
  endfunction

  // flags after a reset trigger: only the causing events touch them
  function automatic wrc_flags_t flags_on_trig(wrc_flags_t f, logic wdt,
                                               logic pin_chg, logic cmp_chg);
    wrc_flags_t n;
    n     = f;
    n.to  = f.to & ~wdt;
    n.pin = f.pin | pin_chg;
    n.cmp = f.cmp | cmp_chg;
    return n;
  endfunction

endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end

  assign q_o = s2;
endmodule

// File: rtl/wrc_chg_det.sv
module wrc_chg_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] val_i,
  input  logic         capture_i,
  input  logic         armed_i,
  output logic         changed_o
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          ref_q <= '0;
    else if (capture_i) ref_q <= val_i;
  end

  assign changed_o = armed_i & (val_i != ref_q);
endmodule

// File: rtl/wrc_rst_pulse.sv
module wrc_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic trig_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)              cnt_q <= '0;
    else if (trig_i)        cnt_q <= LEN_C;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wrc_top.sv
module wrc_top
  import wrc_pkg::*;
#(
  parameter int NPINS      = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             bod_i,
  input  logic             sleep_req_i,
  input  logic             wdt_to_i,
  input  logic             ext_rst_i,
  input  logic             ext_rst_en_i,
  input  logic [NPINS-1:0] mon_pins_i,
  input  logic             pin_wake_en_i,
  input  logic             cmp_i,
  input  logic             cmp_wake_en_i,
  input  logic             port_acc_i,
  output logic             to_flag_o,
  output logic             pd_flag_o,
  output logic             pin_wake_o,
  output logic             cmp_wake_o,
  output logic             osc_en_o,
  output logic             wdt_clr_o,
  output logic             sleeping_o,
  output logic             dev_rst_o
);
  logic [NPINS-1:0] pins_s;
  logic             cmp_s;
  logic             busy_w, trig_w, accept_w, pin_chg_w, cmp_chg_w, ext_w;
  logic             sleep_q, clr_q;
  wrc_flags_t       flags_q;

  wrc_sync #(.W(NPINS)) u_pin_sync (
    .clk(clk), .por_i(por_i), .d_i(mon_pins_i), .q_o(pins_s)
  );
  wrc_sync #(.W(1)) u_cmp_sync (
    .clk(clk), .por_i(por_i), .d_i(cmp_i), .q_o(cmp_s)
  );

  wrc_chg_det #(.W(NPINS)) u_pin_det (
    .clk(clk), .por_i(por_i), .val_i(pins_s),
    .capture_i(port_acc_i | accept_w),
    .armed_i(sleep_q & pin_wake_en_i), .changed_o(pin_chg_w)
  );
  wrc_chg_det #(.W(1)) u_cmp_det (
    .clk(clk), .por_i(por_i), .val_i(cmp_s),
    .capture_i(accept_w),
    .armed_i(sleep_q & cmp_wake_en_i), .changed_o(cmp_chg_w)
  );

  wrc_rst_pulse #(.LEN(RST_CYCLES)) u_pulse (
    .clk(clk), .por_i(por_i), .trig_i(trig_w), .busy_o(busy_w)
  );

  assign ext_w    = ext_rst_i & ext_rst_en_i;
  assign trig_w   = ~busy_w & (wdt_to_i | ext_w | bod_i | pin_chg_w | cmp_chg_w);
  assign accept_w = ~busy_w & ~trig_w & sleep_req_i & ~sleep_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      flags_q <= FLAGS_POR;
      sleep_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= accept_w;
      if (trig_w) begin
        flags_q <= flags_on_trig(flags_q, wdt_to_i, pin_chg_w, cmp_chg_w);
        sleep_q <= 1'b0;
      end else if (accept_w) begin
        flags_q <= flags_on_sleep();
        sleep_q <= 1'b1;
      end
    end
  end

  assign to_flag_o  = flags_q.to;
  assign pd_flag_o  = flags_q.pd;
  assign pin_wake_o = flags_q.pin;
  assign cmp_wake_o = flags_q.cmp;
  assign sleeping_o = sleep_q;
  assign osc_en_o   = ~sleep_q;
  assign wdt_clr_o  = clr_q;
  assign dev_rst_o  = busy_w;
endmodule

// File: rtl/wrc_chk.sv
module wrc_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic clk,
  input logic por_i,
  input logic wdt_to_i,
  input logic to_flag_o,
  input logic pd_flag_o,
  input logic pin_wake_o,
  input logic sleeping_o,
  input logic wdt_clr_o,
  input logic dev_rst_o,
  input logic trig_w,
  input logic accept_w
);
  int run_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          run_q <= 0;
    else if (dev_rst_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (por_i)
    accept_w |=> (sleeping_o && to_flag_o && !pd_flag_o && wdt_clr_o));

  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
    wdt_clr_o |=> !wdt_clr_o);

  // R3
  to_clear_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(to_flag_o) |-> $past(wdt_to_i));

  // R7
  pin_flag_src_chk: assert property (@(posedge clk) disable iff (por_i)
    $rose(pin_wake_o) |-> $past(sleeping_o));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (por_i)
    $rose(dev_rst_o) |-> !sleeping_o);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(dev_rst_o) |-> run_q == RST_CYCLES);

  // R10
  pulse_max_chk: assert property (@(posedge clk) disable iff (por_i)
    dev_rst_o |-> run_q < RST_CYCLES);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (por_i)
    dev_rst_o |-> !trig_w && !accept_w);

  // R13
  pd_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    $rose(pd_flag_o) |-> 1'b0);
endmodule

bind wrc_top wrc_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .por_i(por_i), .wdt_to_i(wdt_to_i), .to_flag_o(to_flag_o),
  .pd_flag_o(pd_flag_o), .pin_wake_o(pin_wake_o), .sleeping_o(sleeping_o),
  .wdt_clr_o(wdt_clr_o), .dev_rst_o(dev_rst_o), .trig_w(trig_w),
  .accept_w(accept_w)
);

// File: tb/sim_wrc_top.sv
`timescale 1ns/1ps
module sim_wrc_top;
  logic clk = 1'b0;
  logic por = 1'b1, bod = 0, sreq = 0, wdt = 0, ext = 0, ext_en = 0;
  logic [2:0] pins = 3'b000;
  logic pwe = 0, cmp = 0, cwe = 0, pacc = 0;
  logic to_f, pd_f, pw_f, cw_f, osc, clr, slp, rst;
  int vec = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wrc_top u0 (
    .clk(clk), .por_i(por), .bod_i(bod), .sleep_req_i(sreq), .wdt_to_i(wdt),
    .ext_rst_i(ext), .ext_rst_en_i(ext_en), .mon_pins_i(pins),
    .pin_wake_en_i(pwe), .cmp_i(cmp), .cmp_wake_en_i(cwe), .port_acc_i(pacc),
    .to_flag_o(to_f), .pd_flag_o(pd_f), .pin_wake_o(pw_f), .cmp_wake_o(cw_f),
    .osc_en_o(osc), .wdt_clr_o(clr), .sleeping_o(slp), .dev_rst_o(rst)
  );

  // behavioural reference model
  bit [2:0] pq[$];
  bit       cq[$];
  int       m_left;
  bit       m_to, m_pd, m_pw, m_cw, m_sl, m_clr, m_cref;
  bit [2:0] m_ref;

  always @(posedge clk) begin
    if (por) begin
      pq = '{3'b000, 3'b000}; cq = '{1'b0, 1'b0};
      m_left = 0; m_to = 1; m_pd = 1; m_pw = 0; m_cw = 0; m_sl = 0; m_clr = 0;
      m_ref = 0; m_cref = 0;
    end else begin
      bit [2:0] pv; bit cv, pc, cc, go, take;
      pv = pq[0]; cv = cq[0];
      pq.push_back(pins); void'(pq.pop_front());
      cq.push_back(cmp);  void'(cq.pop_front());
      pc   = m_sl && pwe && (pv != m_ref);
      cc   = m_sl && cwe && (cv != m_cref);
      go   = (m_left == 0) && (wdt || (ext && ext_en) || bod || pc || cc);
      take = (m_left == 0) && !go && sreq && !m_sl;
      m_clr = take;
      if (m_left > 0) m_left--;
      if (go) begin
        m_left = 4;
        if (wdt) m_to = 0;
        if (pc) m_pw = 1;
        if (cc) m_cw = 1;
        m_sl = 0;
      end else if (take) begin
        m_to = 1; m_pd = 0; m_pw = 0; m_cw = 0; m_sl = 1; m_cref = cv;
      end
      if (take || pacc) m_ref = pv;
    end
  end

  task automatic cmp1(string tag, int act, int exp);
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!por && !done) begin
    vec++;
    cmp1("R3 timeout flag", to_f, m_to);
    cmp1("R2 power-down flag", pd_f, m_pd);
    cmp1("R5 pin-wake flag", pw_f, m_pw);
    cmp1("R6 comparator-wake flag", cw_f, m_cw);
    cmp1("R2 oscillator enable", osc, !m_sl);
    cmp1("R2 watchdog clear", clr, m_clr);
    cmp1("R10 sleeping", slp, m_sl);
    cmp1("R10 reset request", rst, m_left > 0);
  end

  task automatic chk(string tag, int act, int exp);
    vec++;
    cmp1(tag, act, exp);
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rst(int win, output int n);
    n = 0;
    repeat (win) begin tick(); if (rst) n++; end
  endtask

  task automatic go_sleep();
    sreq = 1; tick(); sreq = 0;
  endtask

  initial begin
    int n;
    tick(3); por = 0; tick();
    // R1 power-on state
    chk("R1 to", to_f, 1); chk("R1 pd", pd_f, 1); chk("R1 pin", pw_f, 0);
    chk("R1 cmp", cw_f, 0); chk("R1 sleep", slp, 0); chk("R1 rst", rst, 0);

    // R2 entry, R5 pin wake, R10 pulse, R13 retention
    pwe = 1; go_sleep();
    chk("R2 sleeping", slp, 1); chk("R2 osc", osc, 0); chk("R2 to", to_f, 1);
    chk("R2 pd", pd_f, 0); chk("R2 clr", clr, 1);
    tick(); chk("R2 clr one cycle", clr, 0);
    tick(3); pins = 3'b010;
    count_rst(12, n);
    chk("R10 pulse length", n, 4); chk("R5 pin wake", pw_f, 1);
    chk("R10 released", slp, 0); chk("R13 to kept", to_f, 1); chk("R13 pd kept", pd_f, 0);

    // R6 comparator wake
    cwe = 1; go_sleep(); tick(3); cmp = 1; tick(10);
    chk("R6 cmp wake", cw_f, 1); chk("R2 pin flag cleared", pw_f, 0);
    chk("R6 awake", slp, 0);

    // R7 awake changes ignored, disabled wakes ignored
    pins = 3'b011; cmp = 0; count_rst(8, n);
    chk("R7 no reset awake", n, 0); chk("R7 no pin flag", pw_f, 0);
    pwe = 0; cwe = 0; go_sleep(); tick(2); pins = 3'b000; cmp = 1; tick(8);
    chk("R7 disabled stays asleep", slp, 1); chk("R7 cmp flag", cw_f, 0);

    // R8 port access moves the reference
    pacc = 1; tick(); pacc = 0; tick(4); pwe = 1; tick(6);
    chk("R8 no wake after access", slp, 1);

    // R4 external reset
    ext = 1; ext_en = 0; tick(4); chk("R4 disabled ignored", slp, 1);
    ext_en = 1; tick(); ext = 0; tick(8);
    chk("R4 woke", slp, 0); chk("R4 to kept", to_f, 1); chk("R4 pd kept", pd_f, 0);
    ext_en = 0;

    // R3 watchdog wake
    pwe = 0; go_sleep(); tick(3); wdt = 1; tick(); wdt = 0; tick(8);
    chk("R3 to cleared", to_f, 0); chk("R3 woke", slp, 0);

    // R9 brown-out
    bod = 1; tick(); bod = 0; count_rst(11, n);
    chk("R9 pulse", n, 3); chk("R9 to kept", to_f, 0); chk("R9 pd kept", pd_f, 0);

    // R12 same-cycle sleep and timeout, then R11 during the pulse
    go_sleep(); tick(3); ext_en = 1; ext = 1; tick(); ext = 0; ext_en = 0; tick(8);
    chk("R12 pre to", to_f, 1);
    sreq = 1; wdt = 1; tick(); sreq = 0; wdt = 0;
    chk("R12 reset", rst, 1); chk("R12 to", to_f, 0); chk("R12 no sleep", slp, 0);
    chk("R12 no clear", clr, 0);
    sreq = 1; tick(); sreq = 0;
    chk("R11 sleep ignored", slp, 0); chk("R11 no clear", clr, 0);
    tick(8);

    // R1 repeated power-on
    por = 1; tick(); por = 0; tick();
    chk("R1 to again", to_f, 1); chk("R1 pd again", pd_f, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule